// File: doc/BRIEF.md
# Single-Word SDR SDRAM Sequencer

This block drives one SDR SDRAM device with a 16-bit data bus, four internal banks, 12 row bits and 8 column bits. After reset it brings the memory up by itself: it raises the clock enable, waits, precharges every bank, runs a group of auto-refresh cycles and then loads a fixed mode word. From then on it keeps the memory refreshed at a fixed interval and serves one word per host request.

The host side is a simple request port. The host drives a request together with a write flag, a word address laid out as {bank, row, column}, two byte enables and the write data, and the block takes it in any cycle where ready is high. Every access opens its row, issues a single read or write with auto-precharge and lets the row close before the block is ready again, so no row stays open between requests. Read data comes back with a one-cycle valid pulse. The memory side gives separate data-in, data-out and output-enable signals for the DQ bus, so a pad ring can build the tristate buffer.

All wait lengths are parameters. The power-up settle time is long by default and can be cut down for short runs.

Top module: `sdr_word_ctrl`

## Requirements
- R1: After reset, the commands issued before the block first becomes ready are exactly, in this order: PRECHARGE with A10 high, INIT_REFS (default 4) AUTO REFRESH commands, and LOAD MODE. Clock enable is low in reset, goes high before the PRECHARGE and never drops after that. Commands are encoded as {cs_n, ras_n, cas_n, we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R2: At least INIT_WAIT clocks separate each of these pairs: clock-enable rise and PRECHARGE, PRECHARGE and the first refresh, the last refresh and LOAD MODE, LOAD MODE and the next command. Refreshes inside the power-up group are at least T_RC clocks apart.
- R3: LOAD MODE drives A = 0x220 with BA = 00. This word sets burst length 1 in bits [2:0], sequential ordering in bit 3, CAS latency 2 in bits [6:4], standard mode in bits [8:7] and single-location writes in bit 9.
- R4: Once the block is set up, an auto-refresh becomes due every REFRESH_RELOAD clocks (default 1386). When the block is idle, consecutive AUTO REFRESH commands are exactly REFRESH_RELOAD clocks apart. A due refresh wins over a host request, and an access in progress can delay it by no more than one access.
- R5: The host address is split into bank = addr[21:20], row = addr[19:8] and column = addr[7:0]. Each access issues ACTIVE with BA = bank and A = row. READ or WRITE then follows as the very next command, at least T_RCD clocks later, with the same BA, A[7:0] = column and A10 high.
- R6: The DQ output enable is high only in the cycle that carries WRITE. In that cycle data-out holds the host word, and DQM bit i is the inverse of host byte enable i. DQM bit 0 masks bits [7:0] and bit 1 masks bits [15:8], so a masked byte keeps its old memory contents.
- R7: Read data is sampled CAS_LAT clocks after READ reaches the memory. The block returns it with a valid pulse exactly one cycle long, T_RCD + CAS_LAT + 3 cycles after the accepting edge.
- R8: Ready is low in reset, during power-up, from the acceptance of a request until its access has ended, and while a refresh is pending or running. While ready is high the memory command is NOP and the output enable is low.
- R9: After WRITE, no command follows for at least T_WR + T_RP clocks. After READ, no command follows for at least CAS_LAT + T_RP clocks. After AUTO REFRESH, no command follows for at least T_RC clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request strobe, taken when host_ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 22 | Word address {bank, row, column} |
| host_be | input | 2 | Byte enables for a write, bit i covers byte i |
| host_wdata | input | 16 | Write data |
| host_ready | output | 1 | Block can take a request this cycle |
| host_rvalid | output | 1 | One-cycle pulse with read data |
| host_rdata | output | 16 | Read data |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ba | output | 2 | Bank select |
| mem_a | output | 12 | Row, column or mode address |
| mem_dqm | output | 2 | Byte masks, high masks the byte |
| mem_dq_in | input | 16 | Data from the memory |
| mem_dq_out | output | 16 | Data to the memory |
| mem_dq_oe | output | 1 | Drive enable for the DQ bus |

## Verification
The assertions check the local cycle rules in every cycle. Clock enable never falls once high. READ and WRITE always carry A10. The LOAD MODE word is fixed. No command follows straight after WRITE. Output enable appears only with WRITE. The bus is quiet while ready is high. No refresh tick is lost, and the read-valid pulse lasts one cycle. Other properties depend on history that spans several commands, and only the bench scenarios and the bench's memory model can show them: the full power-up order and its spacing, the exact refresh spacing when idle, the bank/row/column split, the read latency, and write-then-read data with every byte-enable pattern.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

   // memory command code: {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_LMR = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_ACT = 4'b0011,
      CMD_WR  = 4'b0100,
      CMD_RD  = 4'b0101,
      CMD_NOP = 4'b0111
   } sdr_cmd_e;

   typedef enum logic [3:0] {
      ST_POWER,
      ST_HOLD,
      ST_PALL,
      ST_INIT_REF,
      ST_MODE,
      ST_ARM,
      ST_IDLE,
      ST_XFER
   } seq_state_e;

   // mode word: single-word bursts, sequential order, given CAS latency,
   // standard mode, write bursts limited to one location when single_wr
   function automatic logic [11:0] mode_word(input int cas_lat, input bit single_wr);
      logic [11:0] w;
      w      = '0;
      w[6:4] = cas_lat[2:0];
      w[9]   = single_wr;
      return w;
   endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
   parameter int RELOAD = 1386
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic ack,
   output logic pend
);

   localparam int CNT_W = $clog2(RELOAD);

   logic             armed;
   logic [CNT_W-1:0] cnt;
   logic             tick;

   assign tick = armed && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
         pend  <= 1'b0;
      end else begin
         if (arm) begin
            armed <= 1'b1;
            cnt   <= CNT_W'(RELOAD - 1);
         end else if (armed) begin
            if (cnt == '0) cnt <= CNT_W'(RELOAD - 1);
            else           cnt <= cnt - CNT_W'(1);
         end
         if (tick)     pend <= 1'b1;
         else if (ack) pend <= 1'b0;
      end
   end

   // a new interval must never expire while the previous one is still owed
   assert_no_lost_refresh_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> !pend);
   assert_ack_when_due_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> pend);

endmodule

// File: rtl/sdr_read_capture.sv
module sdr_read_capture #(
   parameter int DATA_W  = 16,
   parameter int CAS_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_cmd,
   input  logic [DATA_W-1:0] dq_in,
   output logic              rvalid,
   output logic [DATA_W-1:0] rdata
);

   logic take;

   generate
      if (CAS_LAT == 1) begin : g_lat_one
         logic stage;
         always_ff @(posedge clk) begin
            if (!rst_n) stage <= 1'b0;
            else        stage <= rd_cmd;
         end
         assign take = stage;
      end else begin : g_lat_chain
         logic [CAS_LAT-1:0] stage;
         always_ff @(posedge clk) begin
            if (!rst_n) stage <= '0;
            else        stage <= {stage[CAS_LAT-2:0], rd_cmd};
         end
         assign take = stage[CAS_LAT-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         rvalid <= take;
         if (take) rdata <= dq_in;
      end
   end

   assert_rvalid_single_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |=> !rvalid);

endmodule

// File: rtl/sdr_cmd_fsm.sv
module sdr_cmd_fsm
   import sdr_seq_pkg::*;
#(
   parameter int BANK_W    = 2,
   parameter int ROW_W     = 12,
   parameter int COL_W     = 8,
   parameter int DATA_W    = 16,
   parameter int CAS_LAT   = 2,
   parameter int INIT_WAIT = 9000000,
   parameter int INIT_REFS = 4,
   parameter int T_RCD     = 2,
   parameter int T_RP      = 2,
   parameter int T_WR      = 2,
   parameter int T_RC      = 2,
   localparam int BE_W     = DATA_W / 8,
   localparam int HADDR_W  = BANK_W + ROW_W + COL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_req,
   input  logic               host_we,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic [BE_W-1:0]    host_be,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic               host_ready,
   input  logic               ref_pend,
   output logic               ref_ack,
   output logic               ref_arm,
   output logic               cke,
   output sdr_cmd_e           cmd,
   output logic [BANK_W-1:0]  ba,
   output logic [ROW_W-1:0]   a,
   output logic [BE_W-1:0]    dqm,
   output logic [DATA_W-1:0]  dq_out,
   output logic               dq_oe
);

   localparam int SPAN   = INIT_WAIT + T_WR + T_RP + CAS_LAT + T_RC + T_RCD + 2;
   localparam int WAIT_W = $clog2(SPAN);
   localparam int NREF_W = $clog2(INIT_REFS + 1);

   localparam logic [WAIT_W-1:0] LD_INIT = WAIT_W'(INIT_WAIT - 1);
   localparam logic [WAIT_W-1:0] LD_RC   = WAIT_W'(T_RC - 1);
   localparam logic [WAIT_W-1:0] LD_RCD  = WAIT_W'(T_RCD - 1);
   localparam logic [WAIT_W-1:0] LD_WR   = WAIT_W'(T_WR + T_RP - 1);
   localparam logic [WAIT_W-1:0] LD_RD   = WAIT_W'(CAS_LAT + T_RP - 1);

   localparam logic [ROW_W-1:0] AP_BIT = ROW_W'(1) << 10;
   localparam logic [ROW_W-1:0] MODE   = ROW_W'(mode_word(CAS_LAT, 1'b1));

   seq_state_e         state, ret;
   logic [WAIT_W-1:0]  cnt;
   logic [NREF_W-1:0]  nref;
   logic               lat_we;
   logic [BANK_W-1:0]  lat_bank;
   logic [COL_W-1:0]   lat_col;
   logic [BE_W-1:0]    lat_be;
   logic [DATA_W-1:0]  lat_wdata;

   assign host_ready = (state == ST_IDLE) && !ref_pend;
   assign ref_ack    = (state == ST_IDLE) && ref_pend;
   assign ref_arm    = (state == ST_ARM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_POWER;
         ret       <= ST_POWER;
         cnt       <= '0;
         nref      <= '0;
         cke       <= 1'b0;
         cmd       <= CMD_NOP;
         ba        <= '0;
         a         <= '0;
         dqm       <= '0;
         dq_out    <= '0;
         dq_oe     <= 1'b0;
         lat_we    <= 1'b0;
         lat_bank  <= '0;
         lat_col   <= '0;
         lat_be    <= '0;
         lat_wdata <= '0;
      end else begin
         cmd   <= CMD_NOP;
         dq_oe <= 1'b0;
         dqm   <= '0;
         unique case (state)
            ST_POWER: begin
               cke   <= 1'b1;
               cnt   <= LD_INIT;
               ret   <= ST_PALL;
               state <= ST_HOLD;
            end
            ST_HOLD: begin
               if (cnt == '0) state <= ret;
               else           cnt   <= cnt - WAIT_W'(1);
            end
            ST_PALL: begin
               cmd   <= CMD_PRE;
               ba    <= '0;
               a     <= AP_BIT;
               nref  <= '0;
               cnt   <= LD_INIT;
               ret   <= ST_INIT_REF;
               state <= ST_HOLD;
            end
            ST_INIT_REF: begin
               cmd   <= CMD_REF;
               nref  <= nref + NREF_W'(1);
               state <= ST_HOLD;
               if (nref == NREF_W'(INIT_REFS - 1)) begin
                  cnt <= LD_INIT;
                  ret <= ST_MODE;
               end else begin
                  cnt <= LD_RC;
                  ret <= ST_INIT_REF;
               end
            end
            ST_MODE: begin
               cmd   <= CMD_LMR;
               ba    <= '0;
               a     <= MODE;
               cnt   <= LD_INIT;
               ret   <= ST_ARM;
               state <= ST_HOLD;
            end
            ST_ARM: state <= ST_IDLE;
            ST_IDLE: begin
               if (ref_pend) begin
                  cmd   <= CMD_REF;
                  cnt   <= LD_RC;
                  ret   <= ST_IDLE;
                  state <= ST_HOLD;
               end else if (host_req) begin
                  lat_we    <= host_we;
                  lat_bank  <= host_addr[HADDR_W-1 -: BANK_W];
                  lat_col   <= host_addr[COL_W-1:0];
                  lat_be    <= host_be;
                  lat_wdata <= host_wdata;
                  cmd       <= CMD_ACT;
                  ba        <= host_addr[HADDR_W-1 -: BANK_W];
                  a         <= host_addr[COL_W +: ROW_W];
                  cnt       <= LD_RCD;
                  ret       <= ST_XFER;
                  state     <= ST_HOLD;
               end
            end
            ST_XFER: begin
               ba    <= lat_bank;
               a     <= ROW_W'(lat_col) | AP_BIT;
               ret   <= ST_IDLE;
               state <= ST_HOLD;
               if (lat_we) begin
                  cmd    <= CMD_WR;
                  dq_out <= lat_wdata;
                  dq_oe  <= 1'b1;
                  dqm    <= ~lat_be;
                  cnt    <= LD_WR;
               end else begin
                  cmd <= CMD_RD;
                  cnt <= LD_RD;
               end
            end
            default: state <= ST_POWER;
         endcase
      end
   end

   assert_cke_stays_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);
   assert_auto_precharge_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_RD || cmd == CMD_WR) |-> a[10]);
   assert_mode_word_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_LMR) |-> (a == ROW_W'(12'h220) && ba == '0));
   assert_write_recovery_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_WR) |=> (cmd == CMD_NOP));

endmodule

// File: rtl/sdr_word_ctrl.sv
module sdr_word_ctrl
   import sdr_seq_pkg::*;
#(
   parameter int DATA_W         = 16,
   parameter int BANK_W         = 2,
   parameter int ROW_W          = 12,
   parameter int COL_W          = 8,
   parameter int CAS_LAT        = 2,
   parameter int INIT_WAIT      = 9000000,
   parameter int INIT_REFS      = 4,
   parameter int REFRESH_RELOAD = 1386,
   parameter int T_MRD          = 2,
   parameter int T_RCD          = 2,
   parameter int T_RP           = 2,
   parameter int T_WR           = 2,
   parameter int T_RC           = 2,
   localparam int BE_W          = DATA_W / 8,
   localparam int HADDR_W       = BANK_W + ROW_W + COL_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_req,
   input  logic               host_we,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic [BE_W-1:0]    host_be,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic               host_ready,
   output logic               host_rvalid,
   output logic [DATA_W-1:0]  host_rdata,
   output logic               mem_cke,
   output logic               mem_cs_n,
   output logic               mem_ras_n,
   output logic               mem_cas_n,
   output logic               mem_we_n,
   output logic [BANK_W-1:0]  mem_ba,
   output logic [ROW_W-1:0]   mem_a,
   output logic [BE_W-1:0]    mem_dqm,
   input  logic [DATA_W-1:0]  mem_dq_in,
   output logic [DATA_W-1:0]  mem_dq_out,
   output logic               mem_dq_oe
);

   generate
      if (ROW_W < 11 || COL_W > 10) begin : g_bad_geometry
         $error("row bus must reach A10 and columns must sit below it");
      end
      if (DATA_W % 8 != 0) begin : g_bad_width
         $error("data width must be whole bytes");
      end
      if (CAS_LAT < 1 || CAS_LAT > 3) begin : g_bad_cl
         $error("CAS latency must be 1 to 3");
      end
      if (T_RCD < 1 || T_RP < 1 || T_WR < 1 || T_RC < 1) begin : g_bad_timing
         $error("every timing must be at least one clock");
      end
      if (INIT_WAIT < T_MRD || INIT_WAIT < 1 || INIT_REFS < 1) begin : g_bad_init
         $error("power-up settle must cover the mode load delay");
      end
      if (REFRESH_RELOAD < 32) begin : g_bad_refresh
         $error("refresh interval too short to fit an access");
      end
   endgenerate

   sdr_cmd_e cmd;
   logic     ref_pend, ref_ack, ref_arm;

   sdr_cmd_fsm #(
      .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
      .CAS_LAT(CAS_LAT), .INIT_WAIT(INIT_WAIT), .INIT_REFS(INIT_REFS),
      .T_RCD(T_RCD), .T_RP(T_RP), .T_WR(T_WR), .T_RC(T_RC)
   ) i_fsm (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_be(host_be), .host_wdata(host_wdata), .host_ready(host_ready),
      .ref_pend(ref_pend), .ref_ack(ref_ack), .ref_arm(ref_arm),
      .cke(mem_cke), .cmd(cmd), .ba(mem_ba), .a(mem_a), .dqm(mem_dqm),
      .dq_out(mem_dq_out), .dq_oe(mem_dq_oe)
   );

   sdr_refresh_timer #(.RELOAD(REFRESH_RELOAD)) i_refresh (
      .clk(clk), .rst_n(rst_n), .arm(ref_arm), .ack(ref_ack), .pend(ref_pend)
   );

   sdr_read_capture #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) i_capture (
      .clk(clk), .rst_n(rst_n), .rd_cmd(cmd == CMD_RD), .dq_in(mem_dq_in),
      .rvalid(host_rvalid), .rdata(host_rdata)
   );

   assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd;

   assert_oe_with_write_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0100));
   assert_quiet_when_ready_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> ({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == 4'b0111 && !mem_dq_oe));

endmodule

// File: tb/test_sdr_word_ctrl.sv
`timescale 1ns/1ps
module test_sdr_word_ctrl;

   localparam int IW   = 20;
   localparam int RL   = 200;
   localparam int NREF = 4;
   localparam int TRCD = 2, TRP = 2, TWR = 2, TRC = 2, TMRD = 2, CL = 2;
   localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                          C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                          C_LMR = 4'b0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0;
   logic [21:0] host_addr = '0;
   logic [1:0]  host_be = '0;
   logic [15:0] host_wdata = '0;
   logic        host_ready, host_rvalid;
   logic [15:0] host_rdata;
   logic        mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
   logic [1:0]  mem_ba, mem_dqm;
   logic [11:0] mem_a;
   logic [15:0] mem_dq_in = 16'hDEAD;
   logic [15:0] mem_dq_out;
   logic        mem_dq_oe;

   always #2 clk = ~clk;

   sdr_word_ctrl #(
      .INIT_WAIT(IW), .INIT_REFS(NREF), .REFRESH_RELOAD(RL), .CAS_LAT(CL),
      .T_MRD(TMRD), .T_RCD(TRCD), .T_RP(TRP), .T_WR(TWR), .T_RC(TRC)
   ) i_sdr_word_ctrl (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
      .host_addr(host_addr), .host_be(host_be), .host_wdata(host_wdata),
      .host_ready(host_ready), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
      .mem_cke(mem_cke), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
      .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_a(mem_a),
      .mem_dqm(mem_dqm), .mem_dq_in(mem_dq_in), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe)
   );

   int n_chk = 0, n_fail = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                         input logic [1:0] be);
      logic [15:0] r = old;
      if (be[0]) r[7:0]  = d[7:0];
      if (be[1]) r[15:8] = d[15:8];
      return r;
   endfunction

   // memory model and bus monitor, sampled between clock edges
   logic [15:0] model_mem [int];
   logic [15:0] shadow [int];
   logic [11:0] open_row [4];
   int          cyc = 0, cke_rise = -1;
   bit          lmr_seen = 0;
   int          ninit = 0;
   logic [3:0]  init_cmd [8];
   logic [11:0] init_a [8];
   logic [1:0]  init_ba [8];
   int          init_cyc [8];
   logic [3:0]  last_cmd = C_NOP;
   int          last_cyc = 0;
   logic [1:0]  act_ba = '0;
   int          rd_cnt = 0, rd_addr = 0;
   int          early_ready = 0, oe_bad = 0;
   int          ref_count = 0, ref_last = -1, ref_prev = -1, ref_max_gap = 0;
   int          exp_addr = 0;
   logic [15:0] exp_wdata = '0;
   logic [1:0]  exp_be = '0;

   function automatic logic [15:0] model_rd(input int adr);
      return model_mem.exists(adr) ? model_mem[adr] : 16'h0000;
   endfunction

   always @(negedge clk) begin
      logic [3:0] c;
      int gap, adr;
      c = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
      cyc++;
      if (mem_cke && cke_rise < 0) cke_rise = cyc;
      if (host_ready && !lmr_seen) early_ready++;
      if (mem_dq_oe && c != C_WR) oe_bad++;
      if (rd_cnt > 0) begin
         rd_cnt--;
         mem_dq_in = (rd_cnt == 0) ? model_rd(rd_addr) : 16'hDEAD;
      end else mem_dq_in = 16'hDEAD;
      if (rst_n && c != C_NOP) begin
         gap = cyc - last_cyc;
         if (!lmr_seen && ninit < 8) begin
            init_cmd[ninit] = c; init_a[ninit] = mem_a;
            init_ba[ninit] = mem_ba; init_cyc[ninit] = cyc; ninit++;
         end
         if (lmr_seen) begin
            case (last_cmd)
               C_REF: check(gap >= TRC, "R9", "gap after refresh", gap, TRC);
               C_WR:  check(gap >= TWR + TRP, "R9", "gap after write", gap, TWR + TRP);
               C_RD:  check(gap >= CL + TRP, "R9", "gap after read", gap, CL + TRP);
               C_LMR: check(gap >= IW, "R2", "gap after mode load", gap, IW);
               default: ;
            endcase
            if (c == C_RD || c == C_WR) begin
               check(last_cmd == C_ACT && gap >= TRCD, "R5", "activate to column gap", gap, TRCD);
               check(mem_a[10] && mem_ba == act_ba, "R5", "auto-precharge / bank", mem_a, 12'h400);
            end
         end
         case (c)
            C_ACT: begin act_ba = mem_ba; open_row[mem_ba] = mem_a; end
            C_WR: begin
               adr = int'({mem_ba, open_row[mem_ba], mem_a[7:0]});
               check(adr == exp_addr, "R5", "write address", adr, exp_addr);
               check(mem_dq_oe && mem_dq_out == exp_wdata, "R6", "write data", mem_dq_out, exp_wdata);
               check(mem_dqm == ~exp_be, "R6", "byte mask", mem_dqm, ~exp_be);
               model_mem[adr] = merge(model_rd(adr), mem_dq_out, ~mem_dqm);
            end
            C_RD: begin
               adr = int'({mem_ba, open_row[mem_ba], mem_a[7:0]});
               check(adr == exp_addr, "R5", "read address", adr, exp_addr);
               rd_cnt = CL; rd_addr = adr;
            end
            C_REF: if (lmr_seen) begin
               ref_count++;
               ref_prev = ref_last; ref_last = cyc;
               if (ref_prev >= 0 && ref_last - ref_prev > ref_max_gap)
                  ref_max_gap = ref_last - ref_prev;
            end
            C_LMR: lmr_seen = 1;
            default: ;
         endcase
         last_cmd = c; last_cyc = cyc;
      end
   end

   task automatic wait_ready();
      @(negedge clk);
      while (!host_ready) @(negedge clk);
   endtask

   task automatic host_write(input int adr, input logic [15:0] d, input logic [1:0] be);
      wait_ready();
      exp_addr = adr; exp_wdata = d; exp_be = be;
      host_req = 1; host_we = 1; host_addr = adr[21:0]; host_be = be; host_wdata = d;
      @(negedge clk);
      host_req = 0; host_we = 0;
      check(!host_ready, "R8", "ready after write accepted", host_ready, 0);
      shadow[adr] = merge(shadow.exists(adr) ? shadow[adr] : 16'h0, d, be);
   endtask

   task automatic host_read(input int adr);
      int t;
      logic [15:0] e;
      wait_ready();
      exp_addr = adr;
      host_req = 1; host_we = 0; host_addr = adr[21:0];
      @(negedge clk);
      host_req = 0;
      check(!host_ready, "R8", "ready after read accepted", host_ready, 0);
      t = 1;
      while (!host_rvalid && t < 40) begin @(negedge clk); t++; end
      e = shadow.exists(adr) ? shadow[adr] : 16'h0;
      check(t == TRCD + CL + 3, "R7", "read latency", t, TRCD + CL + 3);
      check(host_rdata == e, "R7", "read data", host_rdata, e);
      @(negedge clk);
      check(!host_rvalid, "R7", "valid lasts one cycle", host_rvalid, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int pool [12];
      int t, r0, sc;
      void'($urandom(32'd5150));
      repeat (5) @(negedge clk);
      check(!mem_cke, "R1", "clock enable in reset", mem_cke, 0);
      check({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == C_NOP, "R1", "command in reset",
            {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, C_NOP);
      check(!host_ready && !mem_dq_oe, "R8", "ready/oe in reset", host_ready, 0);
      rst_n = 1;
      t = 0;
      while (!host_ready && t < 2000) begin @(negedge clk); t++; end
      check(host_ready, "R8", "ready after power-up", host_ready, 1);

      // power-up order and spacing
      check(ninit == NREF + 2, "R1", "power-up command count", ninit, NREF + 2);
      check(init_cmd[0] == C_PRE && init_a[0][10], "R1", "first command precharge all",
            init_cmd[0], C_PRE);
      sc = 0;
      for (int i = 1; i <= NREF; i++) if (init_cmd[i] == C_REF) sc++;
      check(sc == NREF, "R1", "refresh group", sc, NREF);
      check(init_cmd[NREF+1] == C_LMR, "R1", "mode load last", init_cmd[NREF+1], C_LMR);
      check(init_a[NREF+1] == 12'h220 && init_ba[NREF+1] == 2'b00, "R3", "mode word",
            init_a[NREF+1], 12'h220);
      check(cke_rise >= 0 && init_cyc[0] - cke_rise >= IW, "R2", "cke to precharge",
            init_cyc[0] - cke_rise, IW);
      check(init_cyc[1] - init_cyc[0] >= IW, "R2", "precharge to refresh",
            init_cyc[1] - init_cyc[0], IW);
      for (int i = 2; i <= NREF; i++)
         check(init_cyc[i] - init_cyc[i-1] >= TRC, "R2", "refresh spacing in group",
               init_cyc[i] - init_cyc[i-1], TRC);
      check(init_cyc[NREF+1] - init_cyc[NREF] >= IW, "R2", "refresh to mode load",
            init_cyc[NREF+1] - init_cyc[NREF], IW);
      check(early_ready == 0, "R8", "ready during power-up", early_ready, 0);

      // directed corners
      host_write(0, 16'hA5C3, 2'b11);
      host_read(0);
      host_write(22'h3FFFFF, 16'h1234, 2'b11);
      host_read(22'h3FFFFF);
      host_write(22'h2ABC12, 16'hFFFF, 2'b11);
      host_write(22'h2ABC12, 16'h00AB, 2'b01);
      host_read(22'h2ABC12);
      host_write(22'h2ABC12, 16'hCD00, 2'b10);
      host_read(22'h2ABC12);
      host_write(22'h2ABC12, 16'h0000, 2'b00);
      host_read(22'h2ABC12);
      check(shadow[22'h2ABC12] == 16'hCDAB, "R6", "masked byte sequence result",
            shadow[22'h2ABC12], 16'hCDAB);

      // random traffic over a small address pool
      for (int i = 0; i < 12; i++) pool[i] = int'($urandom() & 32'h3FFFFF);
      for (int i = 0; i < 90; i++) begin
         int k = int'($urandom_range(0, 11));
         if ($urandom_range(0, 1) == 1)
            host_write(pool[k], 16'($urandom()), 2'($urandom_range(0, 3)));
         else
            host_read(pool[k]);
      end
      check(ref_max_gap <= RL + TWR + TRP + TRCD + CL + 6, "R4", "refresh delayed by traffic",
            ref_max_gap, RL);

      // idle refresh spacing
      r0 = ref_count;
      repeat (4 * RL + 10) @(negedge clk);
      check(ref_count - r0 >= 3, "R4", "refreshes while idle", ref_count - r0, 4);
      check(ref_last - ref_prev == RL, "R4", "idle refresh interval", ref_last - ref_prev, RL);
      check(oe_bad == 0, "R6", "output enable outside write", oe_bad, 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule